// File: doc/BRIEF.md
# Dual-Bank Endpoint Receive Buffer

This block buffers received data for one bulk OUT endpoint. It has two banks, and each bank holds one maximum-size packet of 64 bytes, so it stores 128 bytes in total. The packet side writes bytes into the bank that is open for reception. It ends each packet with a good-end or an error-end strobe. The reader, either the CPU or a DMA engine, reads the other bank through a 32-bit data port. The port has a word mode that returns four bytes per access and a byte mode that returns one byte per access.

When a good packet lands, a full flag is raised and a size output gives the byte count of the bank being read. The reader pulses a read-done strobe to hand that bank back to the receiver. The flag and size then move to the next filled bank in arrival order. While both banks are held, the receiver side sees a refuse (NAK) level and new packets are dropped without touching stored data. A clear strobe empties both banks at once.

Top module: `ep_rx_dualbank`

## Requirements
- R1: Each bank stores up to BANK_BYTES (64) bytes of one packet. Bytes beyond 64 in one packet are dropped, and the reported size saturates at 64.
- R2: After a good-end strobe (`pkt_end` high, `pkt_abort` low) into an available bank, `full_flag` is high from the next cycle on. It stays high while any filled bank is unreleased.
- R3: `rx_size` gives the byte count of the bank currently presented to the reader, and reads 0 whenever `full_flag` is low.
- R4: Packets alternate between the two banks. While both banks are full, `rx_nak` is high, and a packet written in that state is discarded. Stored data and sizes stay unchanged.
- R5: A `rd_done` pulse while `full_flag` is high releases the presented bank and resets the read pointer. From the next cycle, `full_flag` and `rx_size` show the other bank if it is filled. If it is not, `full_flag` goes low.
- R6: A packet ended by `pkt_abort` (which wins over a simultaneous `pkt_end`) is discarded. Its bank stays available, and `full_flag` and `rx_size` do not change.
- R7: A `buf_clr` pulse empties both banks and resets both pointers. From the next cycle `full_flag`=0, `rx_size`=0, `rx_nak`=0 and `rd_data`=0.
- R8: With `rd_byte_mode`=0, a `rd_en` pulse loads `rd_data` in the next cycle with four bytes, little-endian: the byte at pointer p+k goes in bits 8k+7:8k. Bytes at or past the count read as zero. The pointer advances by 4, clamped at the count.
- R9: With `rd_byte_mode`=1, a `rd_en` pulse loads the byte at the pointer into `rd_data[7:0]`, with bits 31:8 zero, and advances the pointer by 1.
- R10: A read with the pointer at the count, or with `full_flag` low, returns 0 and leaves the pointer unchanged. A `rd_done` with `full_flag` low is ignored.
- R11: After reset, `full_flag`, `rx_size`, `rx_nak` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_wr_en | input | 1 | Receive byte valid |
| pkt_wr_data | input | 8 | Receive byte |
| pkt_end | input | 1 | Packet ended without error |
| pkt_abort | input | 1 | Packet ended with error, discard it |
| rx_nak | output | 1 | Both banks full, new packets refused |
| rd_en | input | 1 | Read strobe for the data port |
| rd_byte_mode | input | 1 | 1: one byte per read, 0: four bytes per read |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| rd_done | input | 1 | Reader finished with the presented bank |
| buf_clr | input | 1 | Empty both banks |
| full_flag | output | 1 | A filled bank is presented to the reader |
| rx_size | output | 7 | Byte count of the presented bank |

## Verification
The assertions check the following on every cycle:
- the size bound;
- zero size while empty;
- that the flag and size hold until a release or clear;
- that the refuse level persists and implies a presented bank;
- that an error end leaves the reader's view untouched;
- the effect of a clear;
- the zero upper bits in byte mode and the zero result of a read with no data.

Some behaviour can only be shown by the bench's scenarios, run against a bank-level model:
- data contents and little-endian packing;
- pointer advance and clamping;
- alternation in arrival order;
- that a refused packet does not overwrite stored bytes.

// File: rtl/ep_rx_pkg.sv
// Package: shared constants and types of the dual-bank receive buffer.
// Assumes exactly two banks; bank indices are one bit wide.
package ep_rx_pkg;
    localparam int unsigned EP_BANKS = 2;

    typedef enum logic {
        RD_WORD = 1'b0,
        RD_BYTE = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/ep_rx_wrctl.sv
// Receive-side write control: tracks the byte position inside the packet
// being received, produces the storage write, and decides whether a packet
// end commits a bank. Assumes bank_ready is stable during one packet.
module ep_rx_wrctl #(
    parameter int BANK_BYTES = 64,
    localparam int CW = $clog2(BANK_BYTES + 1),
    localparam int AW = $clog2(BANK_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          pkt_wr_en,
    input  logic [7:0]    pkt_wr_data,
    input  logic          pkt_end,
    input  logic          pkt_abort,
    input  logic          bank_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_data,
    output logic          commit,
    output logic [CW-1:0] commit_cnt
);
    logic [CW-1:0] wr_ptr;
    logic          room;

    // Space is left in the bank while the pointer is below one packet.
    assign room       = wr_ptr < CW'(BANK_BYTES);
    assign mem_we     = pkt_wr_en && bank_ready && room && !clr;
    assign mem_addr   = wr_ptr[AW-1:0];
    assign mem_data   = pkt_wr_data;
    assign commit     = pkt_end && !pkt_abort && bank_ready && !clr;
    assign commit_cnt = wr_ptr + CW'(mem_we);

    // Byte position: restarts at every packet boundary or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (clr || pkt_end || pkt_abort) begin
            wr_ptr <= '0;
        end else if (mem_we) begin
            wr_ptr <= wr_ptr + CW'(1);
        end
    end
endmodule

// File: rtl/ep_rx_store.sv
// Byte storage of both banks with one byte write port and a multi-lane
// read port. Lanes addressed past the bank end return zero. The contents
// are not reset; readers gate them by the stored count.
module ep_rx_store
    import ep_rx_pkg::*;
#(
    parameter int BANK_BYTES = 64,
    parameter int LANES = 4,
    localparam int CW = $clog2(BANK_BYTES + 1),
    localparam int AW = $clog2(BANK_BYTES)
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic                  wbank,
    input  logic [AW-1:0]         waddr,
    input  logic [7:0]            wdata,
    input  logic                  rbank,
    input  logic [CW-1:0]         rbase,
    output logic [LANES-1:0][7:0] rlane
);
    logic [7:0] mem [EP_BANKS][BANK_BYTES];

    // Byte write into the bank open for reception.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wbank][waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CW:0] addr;
        assign addr = {1'b0, rbase} + (CW+1)'(g);
        // Lane read: zero when the address runs off the bank.
        always_comb begin
            if (addr < (CW+1)'(BANK_BYTES)) begin
                rlane[g] = mem[rbank][addr[AW-1:0]];
            end else begin
                rlane[g] = 8'h00;
            end
        end
    end
endmodule

// File: rtl/ep_rx_bankctl.sv
// Bank ownership: per-bank filled flag and byte count, the bank open to
// the receiver and the bank presented to the reader. Both pointers toggle,
// so the reader sees banks in arrival order. A commit and a release can
// never target the same bank in one cycle.
module ep_rx_bankctl
    import ep_rx_pkg::*;
#(
    parameter int BANK_BYTES = 64,
    localparam int CW = $clog2(BANK_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          commit,
    input  logic [CW-1:0] commit_cnt,
    input  logic          release_req,
    output logic          wr_bank,
    output logic          rd_bank,
    output logic          bank_ready,
    output logic          cur_filled,
    output logic [CW-1:0] cur_count,
    output logic          released
);
    logic [EP_BANKS-1:0] filled;
    logic [CW-1:0]       cnt [EP_BANKS];

    assign bank_ready = !filled[wr_bank];
    assign cur_filled = filled[rd_bank];
    assign cur_count  = filled[rd_bank] ? cnt[rd_bank] : '0;
    assign released   = release_req && filled[rd_bank] && !clr;

    for (genvar b = 0; b < EP_BANKS; b++) begin : g_bank
        // Bank state: set on commit into it, cleared on release or clear.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                filled[b] <= 1'b0;
                cnt[b]    <= '0;
            end else if (commit && (wr_bank == 1'(b))) begin
                filled[b] <= 1'b1;
                cnt[b]    <= commit_cnt;
            end else if (released && (rd_bank == 1'(b))) begin
                filled[b] <= 1'b0;
            end
        end
    end

    // Ownership pointers: advance once per committed or released packet.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_bank <= 1'b0;
            rd_bank <= 1'b0;
        end else begin
            if (commit)   wr_bank <= ~wr_bank;
            if (released) rd_bank <= ~rd_bank;
        end
    end
endmodule

// File: rtl/ep_rx_rdctl.sv
// Reader-side control: read pointer inside the presented bank, lane
// masking against the stored count, word or byte packing, and the
// registered data port. Assumes lanes arrive little-endian from storage.
module ep_rx_rdctl
    import ep_rx_pkg::*;
#(
    parameter int BANK_BYTES = 64,
    parameter int LANES = 4,
    localparam int CW = $clog2(BANK_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  rd_en,
    input  rd_mode_e              rd_mode,
    input  logic                  cur_filled,
    input  logic [CW-1:0]         cur_count,
    input  logic                  released,
    input  logic [LANES-1:0][7:0] rlane,
    output logic [CW-1:0]         rptr,
    output logic [LANES*8-1:0]    rd_data
);
    logic [LANES-1:0]       lane_ok;
    logic [LANES-1:0][7:0]  word_val;
    logic [LANES*8-1:0]     next_data;
    logic                   avail;
    logic [CW-1:0]          remaining;
    logic [CW-1:0]          step;

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign lane_ok[g]  = cur_filled &&
                             (({1'b0, rptr} + (CW+1)'(g)) < {1'b0, cur_count});
        assign word_val[g] = lane_ok[g] ? rlane[g] : 8'h00;
    end

    assign avail     = cur_filled && (rptr < cur_count);
    assign remaining = cur_count - rptr;

    // Pointer step: one byte, or a word clamped at the stored count.
    always_comb begin
        if (rd_mode == RD_BYTE) begin
            step = CW'(1);
        end else if (remaining < CW'(LANES)) begin
            step = remaining;
        end else begin
            step = CW'(LANES);
        end
    end

    // Data packing for the selected access width.
    always_comb begin
        if (rd_mode == RD_BYTE) begin
            next_data = {{(LANES*8-8){1'b0}}, word_val[0]};
        end else begin
            next_data = word_val;
        end
    end

    // Data port and pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rptr    <= '0;
            rd_data <= '0;
        end else begin
            if (rd_en) rd_data <= next_data;
            if (released) begin
                rptr <= '0;
            end else if (rd_en && avail) begin
                rptr <= rptr + step;
            end
        end
    end
endmodule

// File: rtl/ep_rx_dualbank.sv
// Top level of the dual-bank endpoint receive buffer: wires write control,
// bank ownership, storage and read control. Inputs are synchronous to clk;
// pkt_abort wins over pkt_end; a packet end may carry a final byte.
module ep_rx_dualbank
    import ep_rx_pkg::*;
#(
    parameter int BANK_BYTES = 64,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int CW = $clog2(BANK_BYTES + 1),
    localparam int AW = $clog2(BANK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_wr_en,
    input  logic [7:0]        pkt_wr_data,
    input  logic              pkt_end,
    input  logic              pkt_abort,
    output logic              rx_nak,
    input  logic              rd_en,
    input  logic              rd_byte_mode,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_done,
    input  logic              buf_clr,
    output logic              full_flag,
    output logic [CW-1:0]     rx_size
);
    logic                  mem_we;
    logic [AW-1:0]         mem_addr;
    logic [7:0]            mem_data;
    logic                  commit;
    logic [CW-1:0]         commit_cnt;
    logic                  wr_bank;
    logic                  rd_bank;
    logic                  bank_ready;
    logic                  cur_filled;
    logic [CW-1:0]         cur_count;
    logic                  released;
    logic [CW-1:0]         rptr;
    logic [LANES-1:0][7:0] rlane;
    rd_mode_e              rd_mode;

    assign rd_mode   = rd_mode_e'(rd_byte_mode);
    assign rx_nak    = !bank_ready;
    assign full_flag = cur_filled;
    assign rx_size   = cur_count;

    ep_rx_wrctl #(.BANK_BYTES(BANK_BYTES)) u_wr (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr),
        .pkt_wr_en(pkt_wr_en), .pkt_wr_data(pkt_wr_data),
        .pkt_end(pkt_end), .pkt_abort(pkt_abort), .bank_ready(bank_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .commit(commit), .commit_cnt(commit_cnt)
    );

    ep_rx_bankctl #(.BANK_BYTES(BANK_BYTES)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr),
        .commit(commit), .commit_cnt(commit_cnt), .release_req(rd_done),
        .wr_bank(wr_bank), .rd_bank(rd_bank), .bank_ready(bank_ready),
        .cur_filled(cur_filled), .cur_count(cur_count), .released(released)
    );

    ep_rx_store #(.BANK_BYTES(BANK_BYTES), .LANES(LANES)) u_store (
        .clk(clk), .we(mem_we), .wbank(wr_bank), .waddr(mem_addr),
        .wdata(mem_data), .rbank(rd_bank), .rbase(rptr), .rlane(rlane)
    );

    ep_rx_rdctl #(.BANK_BYTES(BANK_BYTES), .LANES(LANES)) u_rd (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .rd_en(rd_en),
        .rd_mode(rd_mode), .cur_filled(cur_filled), .cur_count(cur_count),
        .released(released), .rlane(rlane), .rptr(rptr), .rd_data(rd_data)
    );
endmodule

// File: rtl/ep_rx_dualbank_chk.sv
// Checker for the dual-bank receive buffer, observing its ports only.
module ep_rx_dualbank_chk #(
    parameter int BANK_BYTES = 64,
    parameter int DATA_W = 32,
    localparam int CW = $clog2(BANK_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_end,
    input logic              pkt_abort,
    input logic              rx_nak,
    input logic              rd_en,
    input logic              rd_byte_mode,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_done,
    input logic              buf_clr,
    input logic              full_flag,
    input logic [CW-1:0]     rx_size
);
    AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_size <= CW'(BANK_BYTES)); // R1
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        full_flag && !rd_done && !buf_clr |=> full_flag && $stable(rx_size)); // R2
    AST_EMPTY_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        !full_flag |-> rx_size == '0); // R3
    AST_NAK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_nak && !rd_done && !buf_clr |=> rx_nak); // R4
    AST_NAK_PRESENTED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_nak |-> full_flag); // R4
    AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_abort && !rd_done && !buf_clr |=> $stable(full_flag) && $stable(rx_size)); // R6
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        buf_clr |=> !full_flag && !rx_nak && rd_data == '0); // R7
    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_byte_mode && !buf_clr |=> rd_data[DATA_W-1:8] == '0); // R9
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !full_flag && !buf_clr |=> rd_data == '0); // R10
    AST_DONE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && !full_flag && !pkt_end |=> !full_flag); // R10
endmodule

bind ep_rx_dualbank ep_rx_dualbank_chk #(.BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_end(pkt_end), .pkt_abort(pkt_abort),
    .rx_nak(rx_nak), .rd_en(rd_en), .rd_byte_mode(rd_byte_mode),
    .rd_data(rd_data), .rd_done(rd_done), .buf_clr(buf_clr),
    .full_flag(full_flag), .rx_size(rx_size)
);

// File: tb/tb_ep_rx_dualbank.sv
module tb_ep_rx_dualbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_wr_en = 1'b0;
    logic [7:0]  pkt_wr_data = 8'h00;
    logic        pkt_end = 1'b0;
    logic        pkt_abort = 1'b0;
    logic        rx_nak;
    logic        rd_en = 1'b0;
    logic        rd_byte_mode = 1'b0;
    logic [31:0] rd_data;
    logic        rd_done = 1'b0;
    logic        buf_clr = 1'b0;
    logic        full_flag;
    logic [6:0]  rx_size;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    // Bank-level model derived from the requirements.
    logic [7:0] mb [2][64];
    int  mcnt [2];
    bit  mfill [2];
    int  mwb, mrb, mrptr;

    ep_rx_dualbank dut (
        .clk(clk), .rst_n(rst_n), .pkt_wr_en(pkt_wr_en), .pkt_wr_data(pkt_wr_data),
        .pkt_end(pkt_end), .pkt_abort(pkt_abort), .rx_nak(rx_nak),
        .rd_en(rd_en), .rd_byte_mode(rd_byte_mode), .rd_data(rd_data),
        .rd_done(rd_done), .buf_clr(buf_clr), .full_flag(full_flag), .rx_size(rx_size)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        mfill[0] = 0; mfill[1] = 0; mcnt[0] = 0; mcnt[1] = 0;
        mwb = 0; mrb = 0; mrptr = 0;
    endtask

    task automatic chk_status(string req);
        chk({req, " full_flag"}, {31'd0, full_flag}, {31'd0, mfill[mrb]});
        chk({req, " rx_size"}, {25'd0, rx_size}, mfill[mrb] ? mcnt[mrb] : 0);
        chk({req, " rx_nak"}, {31'd0, rx_nak}, {31'd0, mfill[mwb]});
    endtask

    function automatic logic [31:0] exp_read(bit bmode);
        logic [31:0] r = 32'd0;
        if (mfill[mrb] && mrptr < mcnt[mrb]) begin
            if (bmode) r[7:0] = mb[mrb][mrptr];
            else for (int k = 0; k < 4; k++)
                if (mrptr + k < mcnt[mrb]) r[8*k +: 8] = mb[mrb][mrptr + k];
        end
        return r;
    endfunction

    task automatic send_pkt(string req, int len, bit err);
        bit ok = !mfill[mwb];
        for (int i = 0; i < len; i++) begin
            pkt_wr_en = 1'b1;
            pkt_wr_data = 8'($urandom);
            if (ok && i < 64) mb[mwb][i] = pkt_wr_data;
            tick();
        end
        pkt_wr_en = 1'b0;
        pkt_end = !err;
        pkt_abort = err;
        tick();
        pkt_end = 1'b0;
        pkt_abort = 1'b0;
        if (!err && ok) begin
            mfill[mwb] = 1;
            mcnt[mwb] = (len > 64) ? 64 : len;
            mwb ^= 1;
        end
        chk_status(req);
    endtask

    task automatic do_read(string req, bit bmode);
        logic [31:0] e = exp_read(bmode);
        rd_en = 1'b1;
        rd_byte_mode = bmode;
        tick();
        rd_en = 1'b0;
        if (mfill[mrb] && mrptr < mcnt[mrb]) begin
            if (bmode) mrptr += 1;
            else mrptr = (mrptr + 4 > mcnt[mrb]) ? mcnt[mrb] : mrptr + 4;
        end
        chk({req, " rd_data"}, rd_data, e);
    endtask

    task automatic do_release(string req);
        rd_done = 1'b1;
        tick();
        rd_done = 1'b0;
        if (mfill[mrb]) begin
            mfill[mrb] = 0;
            mrb ^= 1;
            mrptr = 0;
        end
        chk_status(req);
    endtask

    task automatic do_clear(string req);
        buf_clr = 1'b1;
        tick();
        buf_clr = 1'b0;
        model_clear();
        chk_status(req);
        chk({req, " rd_data"}, rd_data, 32'd0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        model_clear();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk_status("R11 reset");
        chk("R11 reset rd_data", rd_data, 32'd0);

        // Short packet, word then byte reads, read past the end.
        send_pkt("R2 R3 five-byte packet", 5, 0);
        do_read("R8 word read", 0);
        do_read("R9 byte read", 1);
        do_read("R10 read past count", 1);
        do_read("R10 word past count", 0);
        do_release("R5 release to empty");
        do_release("R10 release while empty");
        do_read("R10 read while empty", 0);

        // Alternation, NAK with both banks full, arrival order.
        send_pkt("R4 first bank", 10, 0);
        send_pkt("R4 second bank", 64, 0);
        send_pkt("R4 refused packet", 3, 0);
        do_read("R4 data intact after NAK", 0);
        do_read("R4 data intact after NAK", 0);
        do_release("R5 next bank in order");
        for (int i = 0; i < 16; i++) do_read("R8 full 64-byte bank", 0);
        do_read("R10 full bank read past end", 0);
        do_release("R5 release last bank");

        // Oversize packet, error packets, zero-length packet.
        send_pkt("R1 oversize packet", 70, 0);
        send_pkt("R6 error into free bank", 8, 1);
        send_pkt("R6 good after error", 6, 0);
        do_release("R5 release oversize");
        do_read("R6 bank after error", 0);
        do_release("R5 release");
        send_pkt("R3 zero-length packet", 0, 0);
        do_read("R10 zero-length read", 1);
        do_release("R5 release zero-length");

        // Clear with both banks held.
        send_pkt("R4 fill a", 12, 0);
        send_pkt("R4 fill b", 20, 0);
        do_read("R8 before clear", 0);
        do_clear("R7 clear");
        send_pkt("R7 after clear", 4, 0);
        do_read("R7 bank zero after clear", 0);

        // Constrained random mix.
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 99);
            if (op < 30) send_pkt("R4 random packet", $urandom_range(0, 68), ($urandom_range(0, 9) == 0));
            else if (op < 55) do_read("R8 random word read", 0);
            else if (op < 80) do_read("R9 random byte read", 1);
            else if (op < 97) do_release("R5 random release");
            else do_clear("R7 random clear");
        end

        summary();
        $finish;
    end
endmodule